// File: doc/BRIEF.md
# Tick-Synchronized Register Write Buffer

This block sits between a fast processor bus and the registers of a slow timekeeping domain. These registers are the time word, the alarm, the stopwatch, the interrupt mask and the prescaler enable. A bus write to one of them is not applied at once. It is parked in a single holding slot, which stores the register index and a 32-bit data word. The write is released toward its register only when the next synchronization tick arrives. While a write waits in the slot, the block reports it as pending. Once the write lands, the block raises a completion flag. Software clears that flag by writing a one to it.

The slot holds one write and never queues. A bus write that arrives while the slot is occupied is discarded without any error indication. Writes to the interrupt status register take a separate path that skips the slot, so they are forwarded at once.

The tick source depends on the committed prescaler enable. When the prescaler is enabled, commits wait for the one-second tick. When it is disabled, commits use the 32.768 kHz sub-second tick. An interrupt output can signal write completion, so software does not have to poll the status word.

Top module: `rtc_wrbuf`

## Requirements
- R1: After reset, `status_word` is zero, `commit_stb`, `istat_stb` and `wc_irq` are low, and the prescaler enable is off. Only bit 14 (pending) and bit 15 (complete) of `status_word` can ever be non-zero.
- R2: A bus write to a buffered index is accepted when no write is pending. The buffered indices are 0 (time), 1 (alarm), 2 (stopwatch), 3 (mask) and 4 (prescaler). Status bit 14 reads 1 from the next cycle and stays set until the commit.
- R3: An active tick while a write is pending causes the following effects in the next cycle. `commit_stb` is high for exactly one cycle, carrying the held index and data. Bit 14 clears in that same cycle and bit 15 sets.
- R4: A buffered write that arrives while another is pending is discarded. The later commit carries the first write's index and data. Bits 14 and 15 are not changed by the discarded write.
- R5: A write to index 5 (interrupt status) bypasses the slot. It produces `istat_stb` with the low 16 data bits in the next cycle, even while a write is pending. It leaves the pending write untouched. If data bit 15 is 1, it clears status bit 15.
- R6: If a commit and a complete-clearing write to index 5 fall in the same cycle, status bit 15 ends set.
- R7: A buffered write presented in the very cycle of the active tick that commits the pending write is discarded. Afterwards no write is pending.
- R8: Committing index 4 sets the prescaler enable from data bit 0. While the enable is 1, only `tick_sec` commits. While it is 0, only `tick_sub` commits.
- R9: `wc_irq` is high exactly when status bit 15 is set and the last committed mask write (index 3) had data bit 15 set.
- R10: Bus writes to index 6 or 7 are ignored: they create no pending write and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Bus write request, one cycle per write |
| bus_wr_idx | input | 3 | Target register index |
| bus_wr_data | input | 32 | Write data |
| tick_sec | input | 1 | One-second sync tick pulse |
| tick_sub | input | 1 | 32.768 kHz sync tick pulse |
| commit_stb | output | 1 | One-cycle write strobe toward a slow register |
| commit_idx | output | 3 | Register index of the commit |
| commit_data | output | 32 | Data of the commit |
| istat_stb | output | 1 | Immediate interrupt status write strobe |
| istat_data | output | 16 | Interrupt status write data |
| status_word | output | 16 | Bit 15 complete, bit 14 pending |
| wc_irq | output | 1 | Write-complete interrupt |

## Verification
Two kinds of event can land in the same cycle, and the bench forces both. First, the commit tick can meet a complete-clearing write to the interrupt status register. The bench drives the tick and the index-5 write together and expects bit 15 to remain set and `istat_stb` to still fire. Second, the commit tick can meet a fresh buffered write. The bench presents both in one cycle, checks that the old write is committed and the slot is empty, and then shows with a further tick that no second commit appears.

// File: rtl/rtcwb_pkg.sv
package rtcwb_pkg;

  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    SEL_TIME   = 3'd0,
    SEL_ALARM  = 3'd1,
    SEL_SWATCH = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_PRESC  = 3'd4,
    SEL_ISTAT  = 3'd5
  } reg_sel_e;

  // Index goes through the holding slot
  function automatic logic is_buffered(logic [IDX_W-1:0] idx);
    return idx <= SEL_PRESC;
  endfunction

  // Index bypasses the slot
  function automatic logic is_bypass(logic [IDX_W-1:0] idx);
    return idx == SEL_ISTAT;
  endfunction

  // Next value of the complete flag: a commit outranks a clear
  function automatic logic next_done(logic cur, logic commit, logic clear);
    if (commit) return 1'b1;
    if (clear)  return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/wb_slot.sv
module wb_slot
  import rtcwb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_data,
  input  logic              tick,
  output logic              pending,
  output logic              fire,
  output logic [IDX_W-1:0]  held_idx,
  output logic [DATA_W-1:0] held_data,
  output logic              commit_stb,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data
);

  logic take;

  assign take = req & ~pending;
  assign fire = tick & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      held_idx  <= '0;
      held_data <= '0;
    end else if (fire) begin
      pending <= 1'b0;
    end else if (take) begin
      pending   <= 1'b1;
      held_idx  <= req_idx;
      held_data <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_stb  <= 1'b0;
      commit_idx  <= '0;
      commit_data <= '0;
    end else begin
      commit_stb <= fire;
      if (fire) begin
        commit_idx  <= held_idx;
        commit_data <= held_data;
      end
    end
  end

endmodule

// File: rtl/wb_tick_sel.sv
module wb_tick_sel
  import rtcwb_pkg::*;
#(
  parameter logic PRESC_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] held_idx,
  input  logic             held_presc_bit,
  input  logic             held_wcie_bit,
  input  logic             tick_sec,
  input  logic             tick_sub,
  output logic             active_tick,
  output logic             presc_en,
  output logic             wcie
);

  assign active_tick = presc_en ? tick_sec : tick_sub;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_en <= PRESC_RST;
      wcie     <= 1'b0;
    end else if (fire) begin
      if (held_idx == SEL_PRESC) presc_en <= held_presc_bit;
      if (held_idx == SEL_MASK)  wcie     <= held_wcie_bit;
    end
  end

endmodule

// File: rtl/wb_flags.sv
module wb_flags
  import rtcwb_pkg::*;
#(
  parameter int STAT_W   = 16,
  parameter int DONE_POS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              istat_wr,
  input  logic [STAT_W-1:0] istat_wdata,
  output logic              done,
  output logic              clr_hit,
  output logic              istat_stb,
  output logic [STAT_W-1:0] istat_data
);

  assign clr_hit = istat_wr & istat_wdata[DONE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      istat_stb  <= 1'b0;
      istat_data <= '0;
    end else begin
      done      <= next_done(done, fire, clr_hit);
      istat_stb <= istat_wr;
      if (istat_wr) istat_data <= istat_wdata;
    end
  end

endmodule

// File: rtl/rtc_wrbuf.sv
module rtc_wrbuf
  import rtcwb_pkg::*;
#(
  parameter int   DATA_W    = 32,
  parameter int   STAT_W    = 16,
  parameter int   PEND_POS  = 14,
  parameter int   DONE_POS  = 15,
  parameter int   WCIE_POS  = 15,
  parameter int   PRESC_POS = 0,
  parameter logic PRESC_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [2:0]        bus_wr_idx,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              tick_sec,
  input  logic              tick_sub,
  output logic              commit_stb,
  output logic [2:0]        commit_idx,
  output logic [DATA_W-1:0] commit_data,
  output logic              istat_stb,
  output logic [STAT_W-1:0] istat_data,
  output logic [STAT_W-1:0] status_word,
  output logic              wc_irq
);

  // Named internal events
  logic              buf_req;
  logic              istat_hit;
  logic              sync_tick;
  logic              slot_pending;
  logic              slot_fire;
  logic [IDX_W-1:0]  slot_idx;
  logic [DATA_W-1:0] slot_data;
  logic              presc_en;
  logic              wcie;
  logic              flag_done;
  logic              flag_clr;

  assign buf_req   = bus_wr_en & is_buffered(bus_wr_idx);
  assign istat_hit = bus_wr_en & is_bypass(bus_wr_idx);

  wb_slot #(.DATA_W(DATA_W)) slot_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (buf_req),
    .req_idx     (bus_wr_idx),
    .req_data    (bus_wr_data),
    .tick        (sync_tick),
    .pending     (slot_pending),
    .fire        (slot_fire),
    .held_idx    (slot_idx),
    .held_data   (slot_data),
    .commit_stb  (commit_stb),
    .commit_idx  (commit_idx),
    .commit_data (commit_data)
  );

  wb_tick_sel #(.PRESC_RST(PRESC_RST)) tick_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fire           (slot_fire),
    .held_idx       (slot_idx),
    .held_presc_bit (slot_data[PRESC_POS]),
    .held_wcie_bit  (slot_data[WCIE_POS]),
    .tick_sec       (tick_sec),
    .tick_sub       (tick_sub),
    .active_tick    (sync_tick),
    .presc_en       (presc_en),
    .wcie           (wcie)
  );

  wb_flags #(.STAT_W(STAT_W), .DONE_POS(DONE_POS)) flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (slot_fire),
    .istat_wr    (istat_hit),
    .istat_wdata (bus_wr_data[STAT_W-1:0]),
    .done        (flag_done),
    .clr_hit     (flag_clr),
    .istat_stb   (istat_stb),
    .istat_data  (istat_data)
  );

  always_comb begin
    status_word           = '0;
    status_word[PEND_POS] = slot_pending;
    status_word[DONE_POS] = flag_done;
  end

  assign wc_irq = flag_done & wcie;

endmodule

// File: rtl/rtc_wrbuf_chk.sv
module rtc_wrbuf_chk #(
  parameter int STAT_W   = 16,
  parameter int PEND_POS = 14,
  parameter int DONE_POS = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_stb,
  input logic [STAT_W-1:0] status_word,
  input logic              wc_irq,
  input logic              pending,
  input logic              fire,
  input logic              buf_req,
  input logic              bad_req,
  input logic              clr_hit,
  input logic              presc_en,
  input logic              tick_sec,
  input logic              tick_sub
);

  assert_commit_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);

  assert_commit_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> (status_word[DONE_POS] && !status_word[PEND_POS]));

  assert_pending_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fire) |=> status_word[PEND_POS]);

  assert_commit_from_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> $past(pending));

  assert_done_only_by_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[DONE_POS] && !fire && !clr_hit) |=> status_word[DONE_POS]);

  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wc_irq |-> status_word[DONE_POS]);

  assert_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_req && !buf_req && !pending) |=> !status_word[PEND_POS]);

  assert_tick_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && (presc_en ? !tick_sec : !tick_sub)) |=> !commit_stb);

endmodule

bind rtc_wrbuf rtc_wrbuf_chk #(
  .STAT_W   (STAT_W),
  .PEND_POS (PEND_POS),
  .DONE_POS (DONE_POS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit_stb  (commit_stb),
  .status_word (status_word),
  .wc_irq      (wc_irq),
  .pending     (slot_pending),
  .fire        (slot_fire),
  .buf_req     (buf_req),
  .bad_req     (bus_wr_en & (bus_wr_idx > 3'd5)),
  .clr_hit     (flag_clr),
  .presc_en    (presc_en),
  .tick_sec    (tick_sec),
  .tick_sub    (tick_sub)
);

// File: tb/rtc_wrbuf_tb.sv
module rtc_wrbuf_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [2:0]  bus_wr_idx = '0;
  logic [31:0] bus_wr_data = '0;
  logic        tick_sec = 1'b0;
  logic        tick_sub = 1'b0;
  logic        commit_stb;
  logic [2:0]  commit_idx;
  logic [31:0] commit_data;
  logic        istat_stb;
  logic [15:0] istat_data;
  logic [15:0] status_word;
  logic        wc_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [15:0] ST_PEND = 16'h4000;
  localparam logic [15:0] ST_DONE = 16'h8000;

  always #2 clk = ~clk;

  rtc_wrbuf dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_idx(bus_wr_idx),
    .bus_wr_data(bus_wr_data), .tick_sec(tick_sec), .tick_sub(tick_sub),
    .commit_stb(commit_stb), .commit_idx(commit_idx), .commit_data(commit_data),
    .istat_stb(istat_stb), .istat_data(istat_data), .status_word(status_word),
    .wc_irq(wc_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: apply inputs at a falling edge, return at the next falling edge
  task automatic cyc(input logic we, input logic [2:0] idx, input logic [31:0] d,
                     input logic ts, input logic tu);
    bus_wr_en = we; bus_wr_idx = idx; bus_wr_data = d;
    tick_sec = ts; tick_sub = tu;
    @(negedge clk);
    bus_wr_en = 1'b0; tick_sec = 1'b0; tick_sub = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status", {16'h0, status_word}, 32'h0);
    check("R1 commit_stb", {31'h0, commit_stb}, 32'h0);
    check("R1 istat_stb", {31'h0, istat_stb}, 32'h0);
    check("R1 wc_irq", {31'h0, wc_irq}, 32'h0);
  endtask

  task automatic t_basic;
    cyc(1, 3'd0, 32'hA5A5_0001, 0, 0);
    check("R2 pending set", {16'h0, status_word}, {16'h0, ST_PEND});
    cyc(0, 3'd0, 32'h0, 1, 0);
    check("R8 sec tick ignored when prescaler off", {31'h0, commit_stb}, 32'h0);
    check("R2 still pending", {16'h0, status_word}, {16'h0, ST_PEND});
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R3 commit strobe", {31'h0, commit_stb}, 32'h1);
    check("R3 commit idx", {29'h0, commit_idx}, 32'h0);
    check("R3 commit data", commit_data, 32'hA5A5_0001);
    check("R3 flags after commit", {16'h0, status_word}, {16'h0, ST_DONE});
    cyc(0, 3'd0, 32'h0, 0, 0);
    check("R3 single-cycle strobe", {31'h0, commit_stb}, 32'h0);
  endtask

  task automatic t_drop;
    cyc(1, 3'd5, 32'hFFFF_8000, 0, 0);
    check("R5 bypass strobe", {31'h0, istat_stb}, 32'h1);
    check("R5 bypass data", {16'h0, istat_data}, 32'h8000);
    check("R5 complete cleared", {16'h0, status_word}, 32'h0);
    cyc(1, 3'd1, 32'h0000_0B0B, 0, 0);
    cyc(1, 3'd2, 32'h0000_0C0C, 0, 0);
    check("R4 flags unchanged by drop", {16'h0, status_word}, {16'h0, ST_PEND});
    cyc(1, 3'd5, 32'h0000_0003, 0, 0);
    check("R5 bypass while pending", {31'h0, istat_stb}, 32'h1);
    check("R5 pending kept", {16'h0, status_word}, {16'h0, ST_PEND});
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R4 first idx committed", {29'h0, commit_idx}, 32'h1);
    check("R4 first data committed", commit_data, 32'h0000_0B0B);
  endtask

  task automatic t_collide_write;
    cyc(1, 3'd2, 32'h0000_0D0D, 0, 0);
    cyc(1, 3'd3, 32'h0000_0E0E, 0, 1);
    check("R7 old write committed", commit_data, 32'h0000_0D0D);
    check("R7 slot empty", {31'h0, status_word[14]}, 32'h0);
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R7 colliding write dropped", {31'h0, commit_stb}, 32'h0);
  endtask

  task automatic t_collide_clear;
    cyc(1, 3'd5, 32'h0000_8000, 0, 0);
    cyc(1, 3'd0, 32'h0000_0F0F, 0, 0);
    cyc(1, 3'd5, 32'h0000_8000, 0, 1);
    check("R6 commit strobe", {31'h0, commit_stb}, 32'h1);
    check("R6 complete survives clear", {16'h0, status_word}, {16'h0, ST_DONE});
    check("R6 bypass still fires", {31'h0, istat_stb}, 32'h1);
  endtask

  task automatic t_irq;
    cyc(1, 3'd5, 32'h0000_8000, 0, 0);
    cyc(1, 3'd3, 32'h0000_8000, 0, 0);
    check("R9 no irq while pending", {31'h0, wc_irq}, 32'h0);
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R9 irq on completion", {31'h0, wc_irq}, 32'h1);
    cyc(1, 3'd5, 32'h0000_8000, 0, 0);
    check("R9 irq drops with clear", {31'h0, wc_irq}, 32'h0);
  endtask

  task automatic t_presc;
    cyc(1, 3'd4, 32'h0000_0001, 0, 0);
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R8 prescaler commit", {29'h0, commit_idx}, 32'h4);
    cyc(1, 3'd0, 32'h0000_1234, 0, 0);
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R8 sub tick ignored when prescaler on", {31'h0, commit_stb}, 32'h0);
    cyc(0, 3'd0, 32'h0, 1, 0);
    check("R8 sec tick commits", commit_data, 32'h0000_1234);
    cyc(1, 3'd4, 32'h0000_0000, 0, 0);
    cyc(0, 3'd0, 32'h0, 1, 0);
    cyc(1, 3'd1, 32'h0000_5678, 0, 0);
    cyc(0, 3'd0, 32'h0, 0, 1);
    check("R8 sub tick after disable", commit_data, 32'h0000_5678);
  endtask

  task automatic t_badidx;
    cyc(1, 3'd5, 32'h0000_8000, 0, 0);
    cyc(1, 3'd6, 32'h0000_0066, 0, 0);
    check("R10 index 6 not pending", {16'h0, status_word}, 32'h0);
    cyc(1, 3'd7, 32'h0000_0077, 0, 1);
    check("R10 index 7 no commit", {31'h0, commit_stb}, 32'h0);
    check("R10 index 7 no bypass", {31'h0, istat_stb}, 32'h0);
    check("R1 only flag bits", {16'h0, status_word & 16'h3FFF}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_drop();
    t_collide_write();
    t_collide_clear();
    t_irq();
    t_presc();
    t_badidx();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule